// File: doc/BRIEF.md
# Pipeline Timing-Error Recovery Controller

This block tracks the instructions in a five-stage in-order pipeline and sequences recovery when a stage register reports a late-arriving (timing-failed) value. It keeps one control slot per pipeline register: the four registers that carry error detection, followed by a final stabilizing register that feeds write-back. Each slot holds an occupied flag, a bubble flag and the address of the instruction it carries. Every slot advances one position per cycle.

When a slot's error input fires, the instruction in that slot moves on as a bubble and can no longer commit. The error is also registered as a flush request. One cycle later the flush logic raises a one-cycle recover strobe with the address of the failed instruction. In the same cycle it empties every slot holding a younger instruction and refuses the fetch. The fetch side then restarts from that address. Nothing is written before the last slot, so the squash leaves architectural state clean. Each error costs several cycles of throughput, and no global stall is needed.

The fetch input is a valid/ready stream. `fetch_ready` drops only in recover cycles, and a fetch offered while it is low is dropped rather than held. The fetch side must re-present from `recover_pc` afterwards. The commit output is valid-only, because write-back cannot push back. A saturating counter reports how many recoveries have happened, so a supply controller can sample the error rate.

Top module: `pipe_recovery_ctrl`

## Requirements
- R1: While `rst_n` is low:
  - all slots read empty (`stage_valid` and `stage_bubble` zero);
  - `recover` is 0;
  - `recovery_count` is 0;
  - `fetch_ready` is 1;
  - `commit_valid` is 0.
- R2: A fetch accepted at a clock edge (`fetch_valid` and `fetch_ready` both high) occupies slot 0 in the next cycle. It then moves up one slot per cycle. `commit_valid` is high, with its address on `commit_pc`, while it sits in slot 4 without a bubble. Commits follow program order.
- R3: The instruction in an erroring slot k moves to slot k+1 with both its `stage_valid` and `stage_bubble` bits set (bit index = slot number). A bubble never raises `commit_valid`.
- R4: An accepted error in slot k at one edge raises `recover` for exactly the next cycle. In that cycle `recover_pc` is the address of the instruction that was in slot k.
- R5: In a recover cycle for slot k, `flush` bits 0..k are 1 and the higher bits are 0. After the edge that ends the cycle, slots 0..k+1 are empty.
- R6: `fetch_ready` is 0 in exactly the recover cycles, and no instruction is accepted during them.
- R7: When several eligible slots report errors in the same cycle, the highest-numbered (oldest) slot is served. Its flush covers every lower slot.
- R8: An error is ignored when its slot is any of the following:
  - empty;
  - holding a bubble;
  - being flushed in that cycle.

  An ignored error raises no `recover` and leaves `recovery_count` unchanged.
- R9: An eligible error in an older slot during a recover cycle starts a second recovery in the following cycle. That recovery uses the older instruction's address and its own flush mask.
- R10: `recovery_count` rises by one in each recover cycle and holds at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch stream: an instruction address is offered |
| fetch_pc | input | 32 | Fetch stream: address of the offered instruction |
| fetch_ready | output | 1 | Fetch stream: offer is taken at this edge (low in recover cycles) |
| stage_err | input | 4 | Timing-error flag of slots 0..3, bit index = slot |
| stage_valid | output | 5 | Occupied flag of slots 0..4 |
| stage_bubble | output | 5 | Bubble flag of slots 0..4 |
| flush | output | 4 | Squash of slots 0..3 in the current cycle |
| recover | output | 1 | One-cycle PC recovery strobe |
| recover_pc | output | 32 | Restart address, valid with `recover` |
| commit_valid | output | 1 | Non-bubble instruction reaching write-back |
| commit_pc | output | 32 | Address of the committing instruction |
| recovery_count | output | CNT_W | Saturating count of recoveries |

## Verification
The assertions assume that `stage_err` is driven only between clock edges and is never X after reset. They also assume a fetch offered while `fetch_ready` is low is simply lost, with no other effect.

The stimulus holds to these assumptions:
- It drives errors and fetches just after the falling edge.
- It restarts its fetch address from `recover_pc` after each strobe.
- Before choosing an error slot, it waits until the pipeline has refilled. The address it expects in that slot is therefore the one it fetched a known number of cycles earlier.

Errors aimed at empty, bubble or flushed slots are deliberate, placed to exercise the ignore rule.

// File: rtl/pipe_recov_pkg.sv
package pipe_recov_pkg;
  parameter int unsigned PC_W = 32;

  typedef struct packed {
    logic            valid;
    logic            bubble;
    logic [PC_W-1:0] pc;
  } slot_t;
endpackage

// File: rtl/recov_slot_pipe.sv
module recov_slot_pipe
  import pipe_recov_pkg::*;
#(
  parameter int unsigned NSLOT = 5,
  localparam int unsigned NERR = NSLOT - 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fetch_valid,
  input  logic                 fetch_ready,
  input  logic [PC_W-1:0]      fetch_pc,
  input  logic [NERR-1:0]      mark,
  input  logic [NERR-1:0]      squash,
  output slot_t [NSLOT-1:0]    slots
);

  // All slots advance every cycle; flush empties, mark turns into a bubble.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slots <= '0;
    end else begin
      slots[0].valid  <= fetch_valid && fetch_ready;
      slots[0].bubble <= 1'b0;
      slots[0].pc     <= fetch_pc;
      for (int j = 1; j < NSLOT; j++) begin
        if (squash[j-1]) begin
          slots[j] <= '0;
        end else begin
          slots[j] <= slots[j-1];
          if (mark[j-1]) slots[j].bubble <= 1'b1;
        end
      end
    end
  end

  a_r6_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_ready |=> !slots[0].valid);

  for (genvar g = 1; g < NSLOT; g++) begin : g_chk
    a_r3_bubble_marked: assert property (@(posedge clk) disable iff (!rst_n)
      (mark[g-1] && !squash[g-1]) |=> (slots[g].valid && slots[g].bubble));
    a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      squash[g-1] |=> !slots[g].valid);
  end

endmodule

// File: rtl/recov_err_arbiter.sv
module recov_err_arbiter
  import pipe_recov_pkg::*;
#(
  parameter int unsigned NERR = 4,
  localparam int unsigned IDX_W = (NERR > 1) ? $clog2(NERR) : 1
) (
  input  logic [NERR-1:0]   stage_err,
  input  slot_t [NERR-1:0]  slots,
  input  logic [NERR-1:0]   squash,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic [NERR-1:0]   mark,
  output logic [PC_W-1:0]   hit_pc
);

  // Ascending scan: the last eligible (oldest) slot wins.
  always_comb begin
    hit    = 1'b0;
    idx    = '0;
    hit_pc = '0;
    for (int j = 0; j < NERR; j++) begin
      if (stage_err[j] && slots[j].valid && !slots[j].bubble && !squash[j]) begin
        hit    = 1'b1;
        idx    = IDX_W'(j);
        hit_pc = slots[j].pc;
      end
    end
    mark = hit ? (NERR'(1) << idx) : '0;
  end

endmodule

// File: rtl/recov_flush_ctrl.sv
module recov_flush_ctrl
  import pipe_recov_pkg::*;
#(
  parameter int unsigned NERR  = 4,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned IDX_W = (NERR > 1) ? $clog2(NERR) : 1,
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [IDX_W-1:0]  idx,
  input  logic [PC_W-1:0]   hit_pc,
  output logic              recover,
  output logic [PC_W-1:0]   recover_pc,
  output logic [NERR-1:0]   flush,
  output logic [CNT_W-1:0]  count
);

  logic [IDX_W-1:0] req_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      recover    <= 1'b0;
      req_idx    <= '0;
      recover_pc <= '0;
      count      <= '0;
    end else begin
      recover <= hit;
      if (hit) begin
        req_idx    <= idx;
        recover_pc <= hit_pc;
        if (count != CNT_MAX) count <= count + CNT_W'(1);
      end
    end
  end

  // Thermometer squash of the erroring slot and everything younger.
  always_comb begin
    for (int j = 0; j < NERR; j++) flush[j] = recover && (IDX_W'(j) <= req_idx);
  end

  a_r5_flush_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    recover |-> (flush[0] && ((flush & (flush + NERR'(1))) == '0)));
  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && count != CNT_MAX) |=> (count == $past(count) + CNT_W'(1)));
  a_r10_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit || count == CNT_MAX) |=> $stable(count));

endmodule

// File: rtl/pipe_recovery_ctrl.sv
module pipe_recovery_ctrl
  import pipe_recov_pkg::*;
#(
  parameter int unsigned NSLOT = 5,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned NERR  = NSLOT - 1,
  localparam int unsigned IDX_W = (NERR > 1) ? $clog2(NERR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [PC_W-1:0]   fetch_pc,
  output logic              fetch_ready,
  input  logic [NERR-1:0]   stage_err,
  output logic [NSLOT-1:0]  stage_valid,
  output logic [NSLOT-1:0]  stage_bubble,
  output logic [NERR-1:0]   flush,
  output logic              recover,
  output logic [PC_W-1:0]   recover_pc,
  output logic              commit_valid,
  output logic [PC_W-1:0]   commit_pc,
  output logic [CNT_W-1:0]  recovery_count
);

  slot_t [NSLOT-1:0] slots;
  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic [NERR-1:0]   mark;
  logic [PC_W-1:0]   hit_pc;

  assign fetch_ready = !recover;

  recov_slot_pipe #(.NSLOT(NSLOT)) u_pipe (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_pc(fetch_pc), .mark(mark), .squash(flush), .slots(slots)
  );

  recov_err_arbiter #(.NERR(NERR)) u_arb (
    .stage_err(stage_err), .slots(slots[NERR-1:0]), .squash(flush),
    .hit(hit), .idx(idx), .mark(mark), .hit_pc(hit_pc)
  );

  recov_flush_ctrl #(.NERR(NERR), .CNT_W(CNT_W)) u_flush (
    .clk(clk), .rst_n(rst_n), .hit(hit), .idx(idx), .hit_pc(hit_pc),
    .recover(recover), .recover_pc(recover_pc), .flush(flush), .count(recovery_count)
  );

  always_comb begin
    for (int j = 0; j < NSLOT; j++) begin
      stage_valid[j]  = slots[j].valid;
      stage_bubble[j] = slots[j].bubble;
    end
  end

  // The last slot is the stabilizer ahead of write-back.
  assign commit_valid = slots[NSLOT-1].valid && !slots[NSLOT-1].bubble;
  assign commit_pc    = slots[NSLOT-1].pc;

  a_r4_recover_cause: assert property (@(posedge clk) disable iff (!rst_n)
    recover |-> $past(stage_err != '0));
  a_r3_no_bubble_commit: assert property (@(posedge clk) disable iff (!rst_n)
    stage_bubble[NSLOT-1] |-> !commit_valid);

endmodule

// File: tb/sim_pipe_recovery_ctrl.sv
module sim_pipe_recovery_ctrl;
  localparam int NSLOT = 5;
  localparam int NERR  = 4;
  localparam int CNT_W = 3;
  localparam int CMAX  = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             fetch_valid = 1'b0;
  logic [31:0]      fetch_pc = '0;
  logic             fetch_ready;
  logic [NERR-1:0]  stage_err = '0;
  logic [NSLOT-1:0] stage_valid, stage_bubble;
  logic [NERR-1:0]  flush;
  logic             recover;
  logic [31:0]      recover_pc;
  logic             commit_valid;
  logic [31:0]      commit_pc;
  logic [CNT_W-1:0] recovery_count;

  pipe_recovery_ctrl #(.NSLOT(NSLOT), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .fetch_ready(fetch_ready), .stage_err(stage_err), .stage_valid(stage_valid),
    .stage_bubble(stage_bubble), .flush(flush), .recover(recover),
    .recover_pc(recover_pc), .commit_valid(commit_valid), .commit_pc(commit_pc),
    .recovery_count(recovery_count)
  );

  int checks = 0;
  int fails  = 0;
  int exp_cnt = 0;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Fetch model and history of accepted addresses per cycle.
  bit          fetch_en = 1'b0;
  logic [31:0] cur = '0, last_pc = '0, last_rpc = '0, exp_commit = '0;
  bit          last_acc = 1'b0, last_rec = 1'b0;
  bit          hv [NSLOT];
  logic [31:0] hp [NSLOT];

  always @(negedge clk) begin
    if (last_rec) cur = last_rpc;
    else if (last_acc) cur = cur + 32'd4;
    for (int k = NSLOT - 1; k > 0; k--) begin
      hv[k] = hv[k-1];
      hp[k] = hp[k-1];
    end
    hv[0] = last_acc;
    hp[0] = last_pc;
    fetch_valid = fetch_en;
    fetch_pc    = cur;
    last_acc = fetch_en && fetch_ready;
    last_pc  = cur;
    last_rec = recover;
    last_rpc = recover_pc;
    if (rst_n && commit_valid) begin
      chk(commit_pc == exp_commit, "R2 R3 commit order", commit_pc, exp_commit);
      exp_commit = exp_commit + 32'd4;
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  function automatic int sat_inc(input int v);
    return (v < CMAX) ? v + 1 : CMAX;
  endfunction

  task automatic t_reset();
    settle(3);
    chk(stage_valid == '0, "R1 slots empty", stage_valid, 0);
    chk(stage_bubble == '0, "R1 no bubbles", stage_bubble, 0);
    chk(recover == 1'b0, "R1 recover low", recover, 0);
    chk(recovery_count == '0, "R1 count zero", recovery_count, 0);
    chk(fetch_ready == 1'b1, "R1 fetch ready", fetch_ready, 1);
    chk(commit_valid == 1'b0, "R1 no commit", commit_valid, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_flow();
    fetch_en = 1'b1;
    step();
    chk(stage_valid[0] == 1'b0, "R2 slot0 before accept edge", stage_valid[0], 0);
    step();
    chk(stage_valid[0] == 1'b1, "R2 slot0 after accept", stage_valid[0], 1);
    settle(28);
    chk(exp_commit >= 32'd100, "R2 steady throughput", exp_commit, 100);
  endtask

  task automatic t_single(input int k);
    logic [31:0] epc;
    settle(8);
    epc = hp[k];
    chk(hv[k], "R4 slot occupied before error", hv[k], 1);
    stage_err = NERR'(1) << k;
    step();
    stage_err = '0;
    exp_cnt = sat_inc(exp_cnt);
    chk(recover == 1'b1, "R4 recover strobe", recover, 1);
    chk(recover_pc == epc, "R4 restart address", recover_pc, epc);
    chk(flush == NERR'((1 << (k + 1)) - 1), "R5 flush mask", flush, (1 << (k + 1)) - 1);
    chk(stage_valid[k+1] && stage_bubble[k+1], "R3 bubble in next slot", stage_bubble[k+1], 1);
    chk(fetch_ready == 1'b0, "R6 fetch refused", fetch_ready, 0);
    chk(recovery_count == CNT_W'(exp_cnt), "R10 count step", recovery_count, exp_cnt);
    step();
    chk(recover == 1'b0, "R4 strobe one cycle", recover, 0);
    chk((stage_valid & NSLOT'((1 << (k + 2)) - 1)) == '0, "R5 R6 squashed slots empty",
        stage_valid, 0);
  endtask

  task automatic t_prio();
    logic [31:0] epc;
    settle(8);
    epc = hp[3];
    stage_err = 4'b1010;
    step();
    stage_err = '0;
    exp_cnt = sat_inc(exp_cnt);
    chk(recover_pc == epc, "R7 oldest slot served", recover_pc, epc);
    chk(flush == 4'hF, "R7 flush covers younger", flush, 4'hF);
    chk(stage_bubble[4] == 1'b1, "R7 R3 bubble in stabilizer", stage_bubble[4], 1);
    chk(recovery_count == CNT_W'(exp_cnt), "R10 count on priority", recovery_count, exp_cnt);
    step();
    chk(commit_valid == 1'b0, "R3 bubble not committed", commit_valid, 0);
  endtask

  task automatic t_empty();
    fetch_en = 1'b0;
    settle(8);
    chk(!hv[2], "R8 slot drained", hv[2], 0);
    stage_err = 4'b0100;
    step();
    stage_err = '0;
    chk(recover == 1'b0, "R8 empty slot ignored", recover, 0);
    step();
    chk(recovery_count == CNT_W'(exp_cnt), "R8 count unchanged", recovery_count, exp_cnt);
    fetch_en = 1'b1;
  endtask

  task automatic t_suppress();
    logic [31:0] epc;
    settle(8);
    epc = hp[2];
    stage_err = 4'b0100;
    step();
    exp_cnt = sat_inc(exp_cnt);
    chk(recover_pc == epc, "R4 restart for slot 2", recover_pc, epc);
    stage_err = 4'b1001;
    step();
    stage_err = '0;
    chk(recover == 1'b0, "R8 flushed and bubble slots ignored", recover, 0);
    chk(recovery_count == CNT_W'(exp_cnt), "R8 count unchanged after suppress",
        recovery_count, exp_cnt);
  endtask

  task automatic t_nested();
    logic [31:0] epc1, epc2;
    settle(8);
    epc1 = hp[1];
    stage_err = 4'b0010;
    step();
    exp_cnt = sat_inc(exp_cnt);
    epc2 = hp[3];
    chk(recover_pc == epc1, "R4 first recovery address", recover_pc, epc1);
    stage_err = 4'b1000;
    step();
    stage_err = '0;
    exp_cnt = sat_inc(exp_cnt);
    chk(recover == 1'b1, "R9 second recovery strobe", recover, 1);
    chk(recover_pc == epc2, "R9 older restart address", recover_pc, epc2);
    chk(flush == 4'hF, "R9 second flush mask", flush, 4'hF);
    chk(recovery_count == CNT_W'(exp_cnt), "R10 count saturates", recovery_count, exp_cnt);
    step();
  endtask

  initial begin
    t_reset();
    t_flow();
    for (int k = 0; k < NERR; k++) t_single(k);
    t_prio();
    t_empty();
    t_suppress();
    t_nested();
    settle(12);
    chk(recovery_count == CNT_W'(CMAX), "R10 final saturated count", recovery_count, CMAX);
    chk(exp_commit > 32'd100, "R2 commits after recoveries", exp_commit, 100);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule